// File: doc/BRIEF.md
# Centre-Aligned PWM Timer with Buffered Compare

The block is a dual-slope timer that produces centre-aligned pulse-width modulation on a configurable number of compare channels (two by default). A 16-bit counter climbs from zero to a period endpoint and then falls back to zero. Each channel compares the count against its own compare value and drives its output from the match and the direction of the count. A clock-select input picks a divider of 1, 8, 64, 256 or 1024, or stops the counter. The counter moves only on the divided enable.

The period endpoint has two possible sources. One is a dedicated period register, which leaves every channel free for PWM. The other is channel A's compare value, which lets the period change while the timer runs. Writes to the period register and to the compare registers go into shadow buffers. The values in use are taken from those buffers only when the count sits at zero. As a result, a new period or duty cycle starts on a full, symmetric cycle.

The block keeps a sticky flag per channel that records a compare match, and one flag that records each visit to zero. Each flag is cleared by writing a 1 to its clear input.

Top module: `pwm_center_timer`

## Requirements
- R1: Clock-select values 1, 2, 3, 4 and 5 advance the counter once every 1, 8, 64, 256 and 1024 clocks. Values 0, 6 and 7 hold the count still. After the select value changes, the divider starts counting again from zero, so the first advance comes divider+1 clocks after the change is applied.
- R2: On each enabled step the count rises by one toward the active period endpoint. At the endpoint it turns and falls by one per step to zero, then turns upward again. If the active endpoint is 0, the count stays at 0. `count_down_o` is 1 while the count is falling, and it is also 1 at the zero reached from above.
- R3: With `top_sel_i` = 0, the period endpoint is the active value of the dedicated period register. With `top_sel_i` = 1, it is channel A's (channel 0's) active compare value.
- R4: Writes to the compare and period registers change only their buffers. A buffer is copied to its active value on an enabled step taken while the count is 0. Until that step, a new value has no effect on the count or the outputs.
- R5: In mode 2 (`com_mode_i` field value 2'b10), the output goes high on a step at which the count equals the compare value while counting up. It goes low on such a step while counting down.
- R6: In mode 3 (field value 2'b11), the output levels of R5 are inverted.
- R7: In modes 2 and 3, a compare value of 0 forces the output to the inactive level on every step: low in mode 2, high in mode 3. A compare value at or above the period endpoint forces the active level: high in mode 2, low in mode 3.
- R8: In mode 1 (2'b01), channel A's output inverts on each matching step, but only while channel A supplies the period endpoint. Otherwise, and in mode 0 (2'b00), the output keeps its last level.
- R9: A channel's flag (`cmp_flag_o` bit = channel index) is set on an enabled step at which the count equals that channel's active compare value. `ovf_flag_o` is set on an enabled step taken while the count is 0.
- R10: Driving a clear bit high clears the matching flag at the next clock. If the flag is set in that same clock, the set wins.
- R11: After reset the count is 0 and rising, all outputs and flags are 0, and all buffered and active values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 3 | Divider select: 0 stop, 1 /1, 2 /8, 3 /64, 4 /256, 5 /1024, 6-7 stop |
| top_sel_i | input | 1 | Period source: 0 dedicated register, 1 channel A compare |
| top_wr_i | input | 1 | Write strobe for the period buffer |
| top_wdata_i | input | CNT_W | Period buffer write data |
| cmp_wr_i | input | NUM_CH | Per-channel compare buffer write strobes |
| cmp_wdata_i | input | CNT_W | Compare buffer write data (shared) |
| com_mode_i | input | 2*NUM_CH | Output mode per channel, channel n in bits [2n+1:2n] |
| cmp_flag_clr_i | input | NUM_CH | Write-1 clear of compare flags |
| ovf_flag_clr_i | input | 1 | Write-1 clear of the bottom flag |
| count_o | output | CNT_W | Current count |
| count_down_o | output | 1 | Count direction, 1 = falling |
| pwm_o | output | NUM_CH | Waveform outputs |
| cmp_flag_o | output | NUM_CH | Compare match flags |
| ovf_flag_o | output | 1 | Bottom flag |

## Verification
A reference model drives a scoreboard through several patterns, each of which separates a different kind of fault. The first pattern has one non-inverted and one inverted channel with duty values inside the period. The second writes a new duty and period in mid-period, which separates buffered loading from immediate loading. The third drives compare values at zero and at the endpoint in both polarities, which exposes missing corner rules. The fourth takes the period from channel A in toggle mode, which separates the toggle from the hold of mode 1 on the other channel. Measured step gaps at several select values, taken both right after a select change and in steady state, show whether the divider is wrong or fails to restart. Long stretches with clears held high show whether the flags give priority to set over clear.

// File: rtl/pwm_center_pkg.sv
package pwm_center_pkg;

  localparam int unsigned CLK_SEL_W = 3;
  localparam int unsigned PRE_W     = 11;

  typedef enum logic [1:0] {
    COM_HOLD   = 2'd0,
    COM_TOGGLE = 2'd1,
    COM_NONINV = 2'd2,
    COM_INV    = 2'd3
  } com_mode_e;

  function automatic logic [PRE_W-1:0] sel_to_div(input logic [CLK_SEL_W-1:0] sel);
    logic [PRE_W-1:0] d;
    case (sel)
      3'd1:    d = PRE_W'(1);
      3'd2:    d = PRE_W'(8);
      3'd3:    d = PRE_W'(64);
      3'd4:    d = PRE_W'(256);
      3'd5:    d = PRE_W'(1024);
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_center_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CLK_SEL_W-1:0] sel_i,
  output logic                 tick_o
);

  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [CLK_SEL_W-1:0] sel_q;
  logic [PRE_W-1:0]     div_cnt_q;
  logic [PRE_W-1:0]     div_w;
  logic                 sel_chg;

  assign div_w   = sel_to_div(sel_q);
  assign sel_chg = (sel_i != sel_q);
  assign tick_o  = !sel_chg && (div_w != '0) && (div_cnt_q == div_w - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      div_cnt_q <= '0;
    end else if (sel_chg) begin
      // restart the divider so the first enable is a full period away
      sel_q     <= sel_i;
      div_cnt_q <= '0;
    end else if (div_w == '0 || tick_o) begin
      div_cnt_q <= '0;
    end else begin
      div_cnt_q <= div_cnt_q + ONE;
    end
  end

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] count_o,
  output logic             down_o,
  output logic             bottom_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick_i) begin
      if (top_i == '0) begin
        cnt_q  <= '0;
        down_q <= 1'b0;
      end else if (cnt_q >= top_i) begin
        cnt_q  <= cnt_q - ONE;
        down_q <= 1'b1;
      end else if (cnt_q == '0) begin
        cnt_q  <= ONE;
        down_q <= 1'b0;
      end else if (down_q) begin
        cnt_q  <= cnt_q - ONE;
      end else begin
        cnt_q  <= cnt_q + ONE;
      end
    end
  end

  assign count_o  = cnt_q;
  assign down_o   = down_q;
  assign bottom_o = (cnt_q == '0);

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwm_center_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter bit          CAN_TOGGLE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bottom_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] top_i,
  input  com_mode_e        mode_i,
  input  logic             top_src_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             pwm_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] buf_q, act_q;
  logic             pwm_q, pwm_nxt, flag_q;
  logic             hit, inv, toggle_en;

  if (CAN_TOGGLE) begin : g_tgl
    assign toggle_en = top_src_i;
  end else begin : g_no_tgl
    assign toggle_en = 1'b0;
  end

  assign hit = (count_i == act_q);
  assign inv = (mode_i == COM_INV);

  always_comb begin
    pwm_nxt = pwm_q;
    unique case (mode_i)
      COM_NONINV, COM_INV: begin
        if (act_q == '0)          pwm_nxt = inv;
        else if (act_q >= top_i)  pwm_nxt = ~inv;
        else if (hit)             pwm_nxt = down_i ? inv : ~inv;
      end
      COM_TOGGLE: begin
        if (toggle_en && hit) pwm_nxt = ~pwm_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      act_q  <= '0;
      pwm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (tick_i && bottom_i) act_q <= buf_q;
      if (tick_i) pwm_q <= pwm_nxt;
      flag_q <= (tick_i & hit) | (flag_q & ~flag_clr_i);
    end
  end

  assign cmp_act_o = act_q;
  assign pwm_o     = pwm_q;
  assign flag_o    = flag_q;

endmodule

// File: rtl/pwm_center_timer.sv
module pwm_center_timer
  import pwm_center_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            clk_sel_i,
  input  logic                  top_sel_i,
  input  logic                  top_wr_i,
  input  logic [CNT_W-1:0]      top_wdata_i,
  input  logic [NUM_CH-1:0]     cmp_wr_i,
  input  logic [CNT_W-1:0]      cmp_wdata_i,
  input  logic [2*NUM_CH-1:0]   com_mode_i,
  input  logic [NUM_CH-1:0]     cmp_flag_clr_i,
  input  logic                  ovf_flag_clr_i,
  output logic [CNT_W-1:0]      count_o,
  output logic                  count_down_o,
  output logic [NUM_CH-1:0]     pwm_o,
  output logic [NUM_CH-1:0]     cmp_flag_o,
  output logic                  ovf_flag_o
);

  logic             tick;
  logic [CNT_W-1:0] count;
  logic             down, bottom;
  logic [CNT_W-1:0] top_buf_q, top_act_q, top_eff;
  logic [CNT_W-1:0] cmp_act [NUM_CH];
  logic [CNT_W-1:0] cmp_act_a;
  logic             ovf_q;

  pwm_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (clk_sel_i),
    .tick_o (tick)
  );

  pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .top_i    (top_eff),
    .count_o  (count),
    .down_o   (down),
    .bottom_o (bottom)
  );

  assign cmp_act_a = cmp_act[0];
  assign top_eff   = top_sel_i ? cmp_act_a : top_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_buf_q <= '0;
      top_act_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (top_wr_i) top_buf_q <= top_wdata_i;
      if (tick && bottom) top_act_q <= top_buf_q;
      ovf_q <= (tick & bottom) | (ovf_q & ~ovf_flag_clr_i);
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_cmp_channel #(
      .CNT_W      (CNT_W),
      .CAN_TOGGLE (ch == 0)
    ) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .bottom_i   (bottom),
      .wr_i       (cmp_wr_i[ch]),
      .wdata_i    (cmp_wdata_i),
      .count_i    (count),
      .down_i     (down),
      .top_i      (top_eff),
      .mode_i     (com_mode_e'(com_mode_i[2*ch +: 2])),
      .top_src_i  (top_sel_i),
      .flag_clr_i (cmp_flag_clr_i[ch]),
      .cmp_act_o  (cmp_act[ch]),
      .pwm_o      (pwm_o[ch]),
      .flag_o     (cmp_flag_o[ch])
    );
  end

  assign count_o      = count;
  assign count_down_o = down;
  assign ovf_flag_o   = ovf_q;

endmodule

// File: rtl/pwm_center_timer_chk.sv
module pwm_center_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        clk_sel_i,
  input logic              tick_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [CNT_W-1:0]  cmp_act_a_i,
  input logic [NUM_CH-1:0] cmp_flag_i,
  input logic              ovf_flag_i,
  input logic              ovf_clr_i
);

  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == 3'd0 || clk_sel_i > 3'd5) |=> $stable(count_i)); // R1

  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_i) |->
      (count_i == $past(count_i) + 1'b1 || count_i == $past(count_i) - 1'b1)); // R2

  AST_LOAD_AT_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmp_act_a_i) |-> ($past(count_i) == '0 && $past(tick_i))); // R4

  AST_OVF_AT_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_i) |-> ($past(count_i) == '0)); // R9

  AST_CMPA_FLAG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_flag_i[0]) |-> ($past(count_i) == $past(cmp_act_a_i))); // R9

  AST_OVF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !(tick_i && count_i == '0)) |=> !ovf_flag_i); // R10

endmodule

bind pwm_center_timer pwm_center_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clk_sel_i   (clk_sel_i),
  .tick_i      (tick),
  .count_i     (count_o),
  .cmp_act_a_i (cmp_act_a),
  .cmp_flag_i  (cmp_flag_o),
  .ovf_flag_i  (ovf_flag_o),
  .ovf_clr_i   (ovf_flag_clr_i)
);

// File: tb/sim_pwm_center_timer.sv
`timescale 1ns/1ps
module sim_pwm_center_timer;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  clk_sel_i = '0;
  logic        top_sel_i = 1'b0;
  logic        top_wr_i = 1'b0;
  logic [15:0] top_wdata_i = '0;
  logic [1:0]  cmp_wr_i = '0;
  logic [15:0] cmp_wdata_i = '0;
  logic [3:0]  com_mode_i = '0;
  logic [1:0]  cmp_flag_clr_i = '0;
  logic        ovf_flag_clr_i = 1'b0;
  logic [15:0] count_o;
  logic        count_down_o;
  logic [1:0]  pwm_o, cmp_flag_o;
  logic        ovf_flag_o;

  always #4 clk = ~clk;

  pwm_center_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clk_sel_i(clk_sel_i), .top_sel_i(top_sel_i),
    .top_wr_i(top_wr_i), .top_wdata_i(top_wdata_i), .cmp_wr_i(cmp_wr_i),
    .cmp_wdata_i(cmp_wdata_i), .com_mode_i(com_mode_i), .cmp_flag_clr_i(cmp_flag_clr_i),
    .ovf_flag_clr_i(ovf_flag_clr_i), .count_o(count_o), .count_down_o(count_down_o),
    .pwm_o(pwm_o), .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] cnt;
    logic        dn;
    logic [1:0]  pwm;
    logic [1:0]  cf;
    logic        of;
    string       rq_pwm;
    string       rq_flag;
  } exp_t;

  exp_t sb_q[$];

  // stimulus shadows applied by the driver at each negedge
  logic [2:0] sb_sel = '0;
  logic       sb_tsel = 1'b0;
  logic [3:0] sb_mode = '0;

  // reference model
  logic [15:0] m_cnt, m_tbuf, m_tact;
  logic [15:0] m_cbuf [2];
  logic [15:0] m_cact [2];
  logic        m_dn, m_of;
  logic [1:0]  m_out, m_cf;
  logic [2:0]  m_selq;

  task automatic model_reset();
    m_cnt = '0; m_tbuf = '0; m_tact = '0; m_dn = 1'b0; m_of = 1'b0;
    m_out = '0; m_cf = '0; m_selq = '0;
    for (int c = 0; c < 2; c++) begin m_cbuf[c] = '0; m_cact[c] = '0; end
  endtask

  task automatic model_step(input bit tk, input logic [1:0] wr, input logic [15:0] wd,
                            input bit twr, input logic [15:0] td,
                            input logic [1:0] cclr, input bit oclr);
    logic [15:0] te;
    logic [1:0]  cset;
    bit          oset, bot, hit, inv;
    logic [1:0]  md;
    cset = '0; oset = 1'b0;
    te  = sb_tsel ? m_cact[0] : m_tact;
    bot = (m_cnt == 16'd0);
    if (tk) begin
      for (int c = 0; c < 2; c++) begin
        md  = sb_mode[2*c +: 2];
        hit = (m_cnt == m_cact[c]);
        inv = (md == 2'd3);
        if (hit) cset[c] = 1'b1;
        if (md[1]) begin
          if (m_cact[c] == 16'd0)    m_out[c] = inv;
          else if (m_cact[c] >= te)  m_out[c] = !inv;
          else if (hit)              m_out[c] = m_dn ? inv : !inv;
        end else if (md == 2'd1 && c == 0 && sb_tsel && hit) begin
          m_out[c] = !m_out[c];
        end
      end
      oset = bot;
      if (te == 16'd0) begin m_cnt = '0; m_dn = 1'b0; end
      else if (m_cnt >= te) begin m_cnt = m_cnt - 16'd1; m_dn = 1'b1; end
      else if (m_cnt == 16'd0) begin m_cnt = 16'd1; m_dn = 1'b0; end
      else if (m_dn) m_cnt = m_cnt - 16'd1;
      else m_cnt = m_cnt + 16'd1;
      if (bot) begin
        m_tact = m_tbuf;
        for (int c = 0; c < 2; c++) m_cact[c] = m_cbuf[c];
      end
    end
    for (int c = 0; c < 2; c++) if (wr[c]) m_cbuf[c] = wd;
    if (twr) m_tbuf = td;
    m_cf = cset | (m_cf & ~cclr);
    m_of = oset | (m_of & ~oclr);
  endtask

  // driver: one clock of stimulus, expected result pushed to the scoreboard
  task automatic drive(input logic [1:0] wr, input logic [15:0] wd, input bit twr,
                       input logic [15:0] td, input logic [1:0] cclr, input bit oclr,
                       input string rp, input string rf);
    exp_t e;
    bit   tk;
    @(negedge clk);
    clk_sel_i = sb_sel; top_sel_i = sb_tsel; com_mode_i = sb_mode;
    cmp_wr_i = wr; cmp_wdata_i = wd; top_wr_i = twr; top_wdata_i = td;
    cmp_flag_clr_i = cclr; ovf_flag_clr_i = oclr;
    tk = (sb_sel == m_selq) && (sb_sel == 3'd1);
    m_selq = sb_sel;
    model_step(tk, wr, wd, twr, td, cclr, oclr);
    e.cnt = m_cnt; e.dn = m_dn; e.pwm = m_out; e.cf = m_cf; e.of = m_of;
    e.rq_pwm = rp; e.rq_flag = rf;
    sb_q.push_back(e);
  endtask

  task automatic run(input int n, input string rp, input string rf);
    for (int i = 0; i < n; i++) drive('0, '0, 1'b0, '0, '0, 1'b0, rp, rf);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      bit   ok;
      e = sb_q.pop_front();
      n_chk++;
      ok = 1'b1;
      if (count_o !== e.cnt || count_down_o !== e.dn) begin
        ok = 1'b0;
        $display("FAIL R2 count/dir act=%0d/%0b exp=%0d/%0b", count_o, count_down_o, e.cnt, e.dn);
      end
      if (pwm_o !== e.pwm) begin
        ok = 1'b0;
        $display("FAIL %s pwm act=%b exp=%b (count %0d)", e.rq_pwm, pwm_o, e.pwm, e.cnt);
      end
      if (cmp_flag_o !== e.cf || ovf_flag_o !== e.of) begin
        ok = 1'b0;
        $display("FAIL %s flags act=%b/%b exp=%b/%b", e.rq_flag, cmp_flag_o, ovf_flag_o, e.cf, e.of);
      end
      if (!ok) n_fail++;
    end
  end

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    wait (sb_q.size() == 0);
    @(negedge clk);
    rst_ni = 1'b0;
    sb_sel = '0; sb_tsel = 1'b0; sb_mode = '0;
    clk_sel_i = '0; top_sel_i = 1'b0; com_mode_i = '0; cmp_wr_i = '0; top_wr_i = 1'b0;
    cmp_flag_clr_i = '0; ovf_flag_clr_i = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic gap(output int n);
    logic [15:0] p;
    p = count_o;
    n = 0;
    do begin
      @(posedge clk); #2; n++;
    end while (count_o == p && n < 5000);
  endtask

  initial begin
    int g;
    logic [15:0] hold;
    do_reset();
    @(posedge clk); #2;
    check(count_o == 0, "R11", "reset count", count_o, 0);
    check(count_down_o == 0, "R11", "reset dir", count_down_o, 0);
    check(pwm_o == 0, "R11", "reset pwm", pwm_o, 0);
    check(cmp_flag_o == 0 && ovf_flag_o == 0, "R11", "reset flags", {cmp_flag_o, ovf_flag_o}, 0);

    // S1: non-inverted A, inverted B, fixed period 10
    sb_tsel = 1'b0; sb_mode = 4'b11_10;
    drive(2'b01, 16'd3, 1'b0, '0, '0, 1'b0, "R5", "R9");
    drive(2'b10, 16'd7, 1'b1, 16'd10, '0, 1'b0, "R6", "R9");
    sb_sel = 3'd1;
    run(45, "R5/R6", "R9");
    // R4: mid-period writes take effect only after the next bottom
    drive(2'b01, 16'd6, 1'b1, 16'd6, '0, 1'b0, "R4", "R9");
    run(40, "R4", "R9");
    // R10: clears held high, sets must still win
    for (int i = 0; i < 25; i++) drive('0, '0, 1'b0, '0, 2'b11, 1'b1, "R5/R6", "R10");
    run(10, "R5/R6", "R10");

    // S2: compare at BOTTOM and at TOP
    do_reset();
    sb_mode = 4'b10_10;
    drive(2'b01, 16'd0, 1'b0, '0, '0, 1'b0, "R7", "R9");
    drive(2'b10, 16'd8, 1'b1, 16'd8, '0, 1'b0, "R7", "R9");
    sb_sel = 3'd1;
    run(30, "R7", "R9");
    sb_mode = 4'b11_11;
    run(30, "R7", "R9");

    // S3: period from channel A, toggle on A, mode 1 holds on B
    do_reset();
    sb_tsel = 1'b1; sb_mode = 4'b01_01;
    drive(2'b01, 16'd5, 1'b1, 16'd3, '0, 1'b0, "R3", "R9");
    drive(2'b10, 16'd2, 1'b0, '0, '0, 1'b0, "R8", "R9");
    sb_sel = 3'd1;
    run(40, "R8", "R9");
    sb_mode = 4'b00_01;
    run(20, "R8", "R9");
    sb_mode = 4'b10_01;
    run(25, "R3", "R9");

    // S4: divider
    do_reset();
    drive('0, '0, 1'b1, 16'd200, '0, 1'b0, "R1", "R9");
    sb_sel = 3'd1;
    run(4, "R1", "R9");
    wait (sb_q.size() == 0);
    @(negedge clk); clk_sel_i = 3'd3;
    gap(g);
    gap(g);
    check(g == 64, "R1", "gap /64", g, 64);
    repeat (20) @(posedge clk);
    @(negedge clk); clk_sel_i = 3'd2;
    gap(g);
    check(g == 9, "R1", "first step after select change /8", g, 9);
    gap(g);
    check(g == 8, "R1", "gap /8", g, 8);
    @(negedge clk); clk_sel_i = 3'd4;
    gap(g);
    check(g == 257, "R1", "first step /256", g, 257);
    @(negedge clk); clk_sel_i = 3'd5;
    gap(g);
    gap(g);
    check(g == 1024, "R1", "gap /1024", g, 1024);
    @(negedge clk); clk_sel_i = 3'd0;
    @(posedge clk); #2; hold = count_o;
    repeat (300) @(posedge clk);
    #2 check(count_o == hold, "R1", "select 0 stops", count_o, hold);
    @(negedge clk); clk_sel_i = 3'd7;
    @(posedge clk); #2; hold = count_o;
    repeat (300) @(posedge clk);
    #2 check(count_o == hold, "R1", "select 7 stops", count_o, hold);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule